// File: doc/BRIEF.md
# 8b/10b Line Encoder with Disparity Control

This block turns each accepted byte into a 10-bit transmission symbol. The symbol keeps the line DC balanced and rich in transitions, at a cost of 25% extra line bandwidth. A qualifier marks a byte as a control character instead of data. The block keeps a running disparity from one symbol to the next. A compliance input can override the starting disparity of any single symbol, so that a transmitter can lay down fixed test patterns. A control request for a code that the code set does not define raises an error flag, and the byte is then sent as plain data.

The input and the output are valid/ready streams, and each has a single output register. An input beat is taken when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high when the output register is empty or is being drained in that same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the symbol, its error flag and `out_valid` all stay frozen. No new beat is taken in that state. Reset is synchronous and active high.

Top module: `line_code_enc`

## Requirements
- R1: While reset is applied and just after it, `out_valid` is 0 and `rd_pos` is 0 (negative running disparity).
- R2: A data byte (`in_ctrl`=0) with low bits `in_byte[4:0]` and high bits `in_byte[7:5]` is coded as the standard 8b/10b data character for the current disparity. `out_sym[9:4]` carries the 6-bit sub-block abcdei, `out_sym[3:0]` carries fghj, and `out_sym[9]` is sent first.
- R3: With `in_ctrl`=1, the bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE give the standard control characters. For example, 0xBC from negative disparity gives 10'b0011111010, and from positive disparity gives 10'b1100000101.
- R4: With `in_ctrl`=1 and any other byte, `out_err` is 1 and the symbol is the data coding of that byte. In every other case `out_err` is 0.
- R5: Every symbol holds 4, 5 or 6 ones. It holds 6 only when it starts from negative disparity and 4 only when it starts from positive disparity. `rd_pos` then shows the disparity after that symbol.
- R6: With no override in use, the alternate 3-bit coding for high bits 7 keeps every run of equal bits on the line to at most five. For example, 0xEB from positive disparity gives 10'b1101001000.
- R7: A beat taken with `force_en`=1 is coded from the disparity given by `force_pos` (1 = positive), not from `rd_pos`. Disparity tracking then continues from the result.
- R8: A beat taken at one edge shows up on `out_sym`/`out_err` with `out_valid`=1 after exactly that edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the outputs do not change.
- R10: When no beat is taken, `rd_pos` does not change. If `out_ready` is 1 in that cycle, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Encoder can take a beat |
| in_byte | input | 8 | Byte to encode |
| in_ctrl | input | 1 | 1 = control character request |
| force_en | input | 1 | Override the starting disparity for this beat |
| force_pos | input | 1 | Forced starting disparity, 1 = positive |
| out_valid | output | 1 | Symbol register holds a symbol |
| out_ready | input | 1 | Downstream takes the symbol |
| out_sym | output | 10 | Encoded symbol, bit 9 sent first |
| out_err | output | 1 | Undefined control code was requested |
| rd_pos | output | 1 | Running disparity, 1 = positive |

## Verification
The assertions check on every cycle that the output freezes under stall and that every symbol has a legal weight. They also check that disparity changes only when a beat is taken, and that it flips exactly when the symbol weight is not five. Only the bench's scenarios can show the exact code values for data and control bytes, including the error fallback and the alternate high-bit coding. The same holds for the run-length limit across symbol boundaries and the effect of a forced disparity on a chosen symbol.

// File: rtl/line_code_pkg.sv
package line_code_pkg;
  localparam int BYTE_W    = 8;
  localparam int SYM_W     = 10;
  localparam int LO_W      = 5;
  localparam int HI_W      = BYTE_W - LO_W;
  localparam int LO_CODE_W = LO_W + 1;
  localparam int HI_CODE_W = HI_W + 1;
  localparam logic [LO_W-1:0] X_K28 = LO_W'(28);
  localparam logic [HI_W-1:0] Y_ALL = '1;

  // control characters legal in this code set
  function automatic logic ctl_legal(input logic [LO_W-1:0] x, input logic [HI_W-1:0] y);
    return (x == X_K28) ||
           ((y == Y_ALL) && (x == LO_W'(23) || x == LO_W'(27) || x == LO_W'(29) || x == LO_W'(30)));
  endfunction
endpackage

// File: rtl/enc_lo_sub.sv
module enc_lo_sub
  import line_code_pkg::*;
(
  input  logic [LO_W-1:0]      x,
  input  logic                 k28,
  input  logic                 rd_in,
  output logic [LO_CODE_W-1:0] code,
  output logic                 rd_out
);
  logic [LO_CODE_W-1:0] neg_form;
  logic                 neutral;

  always_comb begin
    unique case (x)
      5'd0:  neg_form = 6'b100111;  5'd1:  neg_form = 6'b011101;
      5'd2:  neg_form = 6'b101101;  5'd3:  neg_form = 6'b110001;
      5'd4:  neg_form = 6'b110101;  5'd5:  neg_form = 6'b101001;
      5'd6:  neg_form = 6'b011001;  5'd7:  neg_form = 6'b111000;
      5'd8:  neg_form = 6'b111001;  5'd9:  neg_form = 6'b100101;
      5'd10: neg_form = 6'b010101;  5'd11: neg_form = 6'b110100;
      5'd12: neg_form = 6'b001101;  5'd13: neg_form = 6'b101100;
      5'd14: neg_form = 6'b011100;  5'd15: neg_form = 6'b010111;
      5'd16: neg_form = 6'b011011;  5'd17: neg_form = 6'b100011;
      5'd18: neg_form = 6'b010011;  5'd19: neg_form = 6'b110010;
      5'd20: neg_form = 6'b001011;  5'd21: neg_form = 6'b101010;
      5'd22: neg_form = 6'b011010;  5'd23: neg_form = 6'b111010;
      5'd24: neg_form = 6'b110011;  5'd25: neg_form = 6'b100110;
      5'd26: neg_form = 6'b010110;  5'd27: neg_form = 6'b110110;
      5'd28: neg_form = 6'b001110;  5'd29: neg_form = 6'b101110;
      5'd30: neg_form = 6'b011110;  default: neg_form = 6'b101011;
    endcase
    if (k28) neg_form = 6'b001111;
    neutral = ($countones(neg_form) == 3);
    // balanced codes keep their form, except the pattern for value 7
    code    = (rd_in && (!neutral || (x == LO_W'(7) && !k28))) ? ~neg_form : neg_form;
    rd_out  = neutral ? rd_in : ~rd_in;
  end
endmodule

// File: rtl/enc_hi_sub.sv
module enc_hi_sub
  import line_code_pkg::*;
(
  input  logic [HI_W-1:0]      y,
  input  logic [LO_W-1:0]      x,
  input  logic                 k_any,
  input  logic                 k28,
  input  logic                 rd_in,
  output logic [HI_CODE_W-1:0] code,
  output logic                 rd_out
);
  logic [HI_CODE_W-1:0] neg_form;
  logic                 alt, neutral, flip;

  always_comb begin
    alt = (y == Y_ALL) &&
          (k_any ||
           (!rd_in && (x == LO_W'(17) || x == LO_W'(18) || x == LO_W'(20))) ||
           ( rd_in && (x == LO_W'(11) || x == LO_W'(13) || x == LO_W'(14))));
    unique case (y)
      3'd0: neg_form = 4'b1011;
      3'd1: neg_form = 4'b1001;
      3'd2: neg_form = 4'b0101;
      3'd3: neg_form = 4'b1100;
      3'd4: neg_form = 4'b1101;
      3'd5: neg_form = 4'b1010;
      3'd6: neg_form = 4'b0110;
      default: neg_form = alt ? 4'b0111 : 4'b1110;
    endcase
    neutral = ($countones(neg_form) == 2);
    flip    = rd_in && (!neutral || y == HI_W'(3));
    // control K28 inverts its balanced tails when entering negative
    if (k28 && neutral && y != HI_W'(3) && !rd_in) flip = 1'b1;
    code   = flip ? ~neg_form : neg_form;
    rd_out = neutral ? rd_in : ~rd_in;
  end
endmodule

// File: rtl/line_code_enc.sv
module line_code_enc
  import line_code_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_ctrl,
  input  logic              force_en,
  input  logic              force_pos,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SYM_W-1:0]  out_sym,
  output logic              out_err,
  output logic              rd_pos
);
  logic [LO_W-1:0]      x;
  logic [HI_W-1:0]      y;
  logic                 legal, k_any, k28, rd_start, rd_mid, rd_end, take;
  logic [LO_CODE_W-1:0] lo_code;
  logic [HI_CODE_W-1:0] hi_code;

  assign x        = in_byte[LO_W-1:0];
  assign y        = in_byte[BYTE_W-1:LO_W];
  assign legal    = ctl_legal(x, y);
  assign k_any    = in_ctrl && legal;
  assign k28      = k_any && (x == X_K28);
  assign rd_start = force_en ? force_pos : rd_pos;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  enc_lo_sub u_lo (.x(x), .k28(k28), .rd_in(rd_start), .code(lo_code), .rd_out(rd_mid));
  enc_hi_sub u_hi (.y(y), .x(x), .k_any(k_any), .k28(k28), .rd_in(rd_mid),
                   .code(hi_code), .rd_out(rd_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_err   <= 1'b0;
      rd_pos    <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_sym   <= {lo_code, hi_code};
      out_err   <= in_ctrl && !legal;
      rd_pos    <= rd_end;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_err)));
  // R5
  sym_weight_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_sym) >= 4 && $countones(out_sym) <= 6));
  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(rd_pos));
  // R5
  rd_track_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (($countones(out_sym) != 5) == (rd_pos != $past(rd_start))));
  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);
endmodule

// File: tb/line_code_enc_test.sv
module line_code_enc_test;
  logic       clk = 0, rst = 1;
  logic       in_valid = 0, in_ctrl = 0, force_en = 0, force_pos = 0, out_ready = 0;
  logic [7:0] in_byte = 0;
  logic       in_ready, out_valid, out_err, rd_pos;
  logic [9:0] out_sym;

  int n_chk = 0, n_fail = 0;
  logic       e_valid = 0, e_err = 0, e_rd = 0, e_ctrl = 0;
  logic [9:0] e_sym = 0;
  logic       last_bit = 0;
  int         run_len = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  line_code_enc uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_ctrl(in_ctrl), .force_en(force_en), .force_pos(force_pos),
    .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym), .out_err(out_err),
    .rd_pos(rd_pos));

  task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // returns {err, rd_after, symbol}
  function automatic logic [11:0] ref_enc(input logic [7:0] b, input logic c, input logic rd);
    logic [4:0] x; logic [2:0] y; logic k, k28, rd1, rd2, alt; logic [5:0] s6; logic [3:0] s4;
    x = b[4:0]; y = b[7:5];
    k = c && ((x == 28) || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
    k28 = k && x == 28;
    case (x)
      0: s6 = 6'b100111; 1: s6 = 6'b011101; 2: s6 = 6'b101101; 3: s6 = 6'b110001;
      4: s6 = 6'b110101; 5: s6 = 6'b101001; 6: s6 = 6'b011001; 7: s6 = 6'b111000;
      8: s6 = 6'b111001; 9: s6 = 6'b100101; 10: s6 = 6'b010101; 11: s6 = 6'b110100;
      12: s6 = 6'b001101; 13: s6 = 6'b101100; 14: s6 = 6'b011100; 15: s6 = 6'b010111;
      16: s6 = 6'b011011; 17: s6 = 6'b100011; 18: s6 = 6'b010011; 19: s6 = 6'b110010;
      20: s6 = 6'b001011; 21: s6 = 6'b101010; 22: s6 = 6'b011010; 23: s6 = 6'b111010;
      24: s6 = 6'b110011; 25: s6 = 6'b100110; 26: s6 = 6'b010110; 27: s6 = 6'b110110;
      28: s6 = 6'b001110; 29: s6 = 6'b101110; 30: s6 = 6'b011110; default: s6 = 6'b101011;
    endcase
    if (k28) s6 = 6'b001111;
    rd1 = ($countones(s6) == 3) ? rd : !rd;
    if (rd && ($countones(s6) != 3 || (x == 7 && !k28))) s6 = ~s6;
    alt = (y == 7) && (k || (!rd1 && (x == 17 || x == 18 || x == 20)) ||
                            (rd1 && (x == 11 || x == 13 || x == 14)));
    case (y)
      0: s4 = 4'b1011; 1: s4 = 4'b1001; 2: s4 = 4'b0101; 3: s4 = 4'b1100;
      4: s4 = 4'b1101; 5: s4 = 4'b1010; 6: s4 = 4'b0110; default: s4 = alt ? 4'b0111 : 4'b1110;
    endcase
    rd2 = ($countones(s4) == 2) ? rd1 : !rd1;
    if ((rd1 && ($countones(s4) != 2 || y == 3)) ||
        (k28 && $countones(s4) == 2 && y != 3 && !rd1)) s4 = ~s4;
    return {c && !k, rd2, s6, s4};
  endfunction

  task automatic step(input logic v, input logic [7:0] b, input logic c,
                      input logic fe, input logic fp, input logic rdy);
    logic acc, start;
    logic [11:0] r;
    in_valid = v; in_byte = b; in_ctrl = c; force_en = fe; force_pos = fp; out_ready = rdy;
    #1;
    check(in_ready == (!e_valid || rdy), "R9 in_ready", {9'b0, in_ready}, {9'b0, (!e_valid || rdy)});
    acc = v && (!e_valid || rdy);
    if (acc) begin
      start = fe ? fp : e_rd;
      r = ref_enc(b, c, start);
      e_err = r[11]; e_rd = r[10]; e_sym = r[9:0]; e_valid = 1; e_ctrl = c;
    end else if (rdy) e_valid = 0;
    @(posedge clk); @(negedge clk);
    check(out_valid == e_valid, "R8/R10 out_valid", {9'b0, out_valid}, {9'b0, e_valid});
    check(rd_pos == e_rd, "R5/R7/R10 rd_pos", {9'b0, rd_pos}, {9'b0, e_rd});
    if (e_valid) begin
      check(out_sym == e_sym, e_ctrl ? "R3/R4 symbol" : "R2 symbol", out_sym, e_sym);
      check(out_err == e_err, "R4 out_err", {9'b0, out_err}, {9'b0, e_err});
    end
    if (acc) begin
      if (fe) run_len = 0;
      for (int i = 9; i >= 0; i--) begin
        if (run_len > 0 && out_sym[i] == last_bit) run_len++;
        else run_len = 1;
        last_bit = out_sym[i];
        if (run_len > 5) break;
      end
      check(run_len <= 5, "R6 run length", 10'(run_len), 10'd5);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(out_valid == 0 && rd_pos == 0, "R1 reset state", {8'b0, out_valid, rd_pos}, 10'b0);
    rst = 0;
    @(negedge clk);
    check(out_valid == 0 && rd_pos == 0, "R1 after reset", {8'b0, out_valid, rd_pos}, 10'b0);
    // directed corner cases
    step(1, 8'hBC, 1, 0, 0, 1);
    check(out_sym == 10'b0011111010, "R3 K28.5 neg", out_sym, 10'b0011111010);
    step(1, 8'hBC, 1, 0, 0, 1);
    check(out_sym == 10'b1100000101, "R3 K28.5 pos", out_sym, 10'b1100000101);
    step(1, 8'hBC, 1, 0, 0, 1);          // back to positive
    step(1, 8'hEB, 0, 0, 0, 1);
    check(out_sym == 10'b1101001000, "R6 alternate high code", out_sym, 10'b1101001000);
    step(1, 8'h00, 0, 1, 0, 1);
    check(out_sym == 10'b1001110100, "R7 forced negative", out_sym, 10'b1001110100);
    step(1, 8'h00, 1, 0, 0, 1);
    check(out_err == 1, "R4 undefined control", {9'b0, out_err}, 10'd1);
    step(1, 8'h55, 0, 0, 0, 0);          // R9 stall begins
    step(1, 8'h66, 0, 0, 0, 0);
    check(in_ready == 0, "R9 stalled ready", {9'b0, in_ready}, 10'd0);
    step(0, 8'h77, 0, 0, 0, 1);          // R10 idle drain
    step(0, 8'h77, 0, 0, 0, 1);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] kb;
      kb = (i < 8) ? {i[2:0], 5'd28} : (i == 8 ? 8'hF7 : i == 9 ? 8'hFB : i == 10 ? 8'hFD : 8'hFE);
      step(1, kb, 1, 0, 0, 1);
    end
    for (int i = 0; i < 256; i++) step(1, 8'(i), 0, 0, 0, 1);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic c, fe;
      c  = ($urandom % 4) == 0;
      fe = ($urandom % 16) == 0;
      step(($urandom % 5) != 0, 8'($urandom), c, fe, 1'($urandom), ($urandom % 4) != 0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule